// File: doc/BRIEF.md
# Status and Mode Flag Bank with Set/Clear Command Word

This block keeps the mode flags and error flags of a serial controller: a run-enable flag, a master-select flag, and six error flags. The hardware sources are transmit overflow, receive overflow, abort, transmit underflow and receive underflow. The sixth error flag, mode error, is changed only by software. Software never writes the flags directly. Each flag instead has its own set bit and its own clear bit in one write-only command word, so software can change any mix of flags with a single write and never needs a read-modify-write.

The five hardware error sources enter as single-cycle event pulses. An event sets its flag only while the matching enable bit in the controller's control word is high. The flags appear together with a pass-through busy indication in a status word at fixed bit positions. The error interrupt is high whenever any error flag is set and the error bit of the interrupt enable word is on.

All flag changes are registered and appear in the status word one clock after the write or event. The busy bit and the interrupt follow their inputs and the flag state combinationally.

Top module: `status_flag_bank`

## Requirements
- R1: After reset every flag is 0, so `statusWord` equals 0 apart from the busy bit, and `errIrq` is 0.
- R2: A write with `cmdValid` high sets flags through these `cmdWord` bits: bit 15 transmit underflow, bit 14 abort, bit 13 receive overflow, bit 12 transmit overflow, bit 7 mode error, bit 5 receive underflow, bit 3 master select, bit 1 enable.
- R3: Such a write clears flags through these bits: bit 11 transmit underflow, bit 10 abort, bit 9 receive overflow, bit 8 transmit overflow, bit 6 mode error, bit 4 receive underflow, bit 2 master select, bit 0 enable.
- R4: When one write has both the set bit and the clear bit of the same flag at 1, and no hardware event sets it, that flag keeps its value.
- R5: While `cmdValid` is 0, `cmdWord` has no effect on any flag.
- R6: A pulse on `hwErrEvent[i]` sets a flag only if `ctrlWord[8+i]` is 1, with i = 0 transmit overflow, 1 receive overflow, 2 abort, 3 transmit underflow, 4 receive underflow. When that enable bit is 0 the event is ignored.
- R7: An enabled hardware event sets its flag even if the same cycle's write clears that flag.
- R8: The status word shows enable at bit 0, master select at bit 1, mode error at bit 7, transmit overflow at bit 8, receive overflow at bit 9, abort at bit 10, transmit underflow at bit 11, receive underflow at bit 12 and busy at bit 13. All other bits read 0.
- R9: Writing 0x0F50 clears all six error flags and leaves enable and master select unchanged.
- R10: `errIrq` is 1 exactly when at least one error flag is 1 and `intEnable[2]` is 1. The other `intEnable` bits (3 frame end, 1 transmit, 0 receive) have no effect on it.
- R11: Status bit 13 follows `busyIn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Qualifies a command word write |
| cmdWord | input | 16 | Write-only set/clear command word |
| ctrlWord | input | 16 | Controller control word; bits 12..8 are the error enables |
| hwErrEvent | input | 5 | Hardware error event pulses |
| busyIn | input | 1 | Busy indication from the shift engine |
| intEnable | input | 4 | Interrupt enable word; bit 2 gates the error interrupt |
| statusWord | output | 16 | Readable status word |
| errIrq | output | 1 | Error interrupt request |

## Verification
The assertions check on every cycle, for each flag, three things. A flag hit by both its set and its clear strobe holds its value. An enabled hardware event always leaves its flag at 1. A lone clear leaves the flag at 0. At the ports they also check that the interrupt stays low while its enable bit is off, and that the enable flag rises only after a write of its set bit. The bench's scenarios are needed to show the rest: the bit mapping of each flag in the command word and in the status word, the ignored writes without `cmdValid`, the enable gating of events against each control bit, and the bulk error-clear pattern. It sweeps every flag under every set/clear combination from both starting values, and every interrupt-enable value against every single error flag.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

  // Flag indices used throughout the block
  localparam int NUM_FLAGS  = 8;
  localparam int NUM_HW_ERR = 5;   // flags 0..4 have hardware sources
  localparam int NUM_ERR    = 6;   // flags 0..5 are error flags
  localparam int IDX_TXOVF  = 0;
  localparam int IDX_RXOVF  = 1;
  localparam int IDX_ABORT  = 2;
  localparam int IDX_TXUNF  = 3;
  localparam int IDX_RXUNF  = 4;
  localparam int IDX_MODEER = 5;
  localparam int IDX_MASTER = 6;
  localparam int IDX_RUN    = 7;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] swSet;
    logic [NUM_FLAGS-1:0] swClr;
    logic [NUM_FLAGS-1:0] hwSet;
  } flagStrobes_t;

  // Command-word bit that sets a flag
  function automatic int setBitOf(input int idx);
    case (idx)
      IDX_TXOVF:  return 12;
      IDX_RXOVF:  return 13;
      IDX_ABORT:  return 14;
      IDX_TXUNF:  return 15;
      IDX_RXUNF:  return 5;
      IDX_MODEER: return 7;
      IDX_MASTER: return 3;
      default:    return 1;
    endcase
  endfunction

  // Command-word bit that clears a flag
  function automatic int clrBitOf(input int idx);
    case (idx)
      IDX_TXOVF:  return 8;
      IDX_RXOVF:  return 9;
      IDX_ABORT:  return 10;
      IDX_TXUNF:  return 11;
      IDX_RXUNF:  return 4;
      IDX_MODEER: return 6;
      IDX_MASTER: return 2;
      default:    return 0;
    endcase
  endfunction

  // Status-word bit that shows a flag
  function automatic int statBitOf(input int idx);
    case (idx)
      IDX_TXOVF:  return 8;
      IDX_RXOVF:  return 9;
      IDX_ABORT:  return 10;
      IDX_TXUNF:  return 11;
      IDX_RXUNF:  return 12;
      IDX_MODEER: return 7;
      IDX_MASTER: return 1;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
  import sflag_pkg::*;
#(
  parameter int CMD_W      = 16,
  parameter int CTRL_W     = 16,
  parameter int ERR_EN_LSB = 8
) (
  input  logic                  cmdValid,
  input  logic [CMD_W-1:0]      cmdWord,
  input  logic [CTRL_W-1:0]     ctrlWord,
  input  logic [NUM_HW_ERR-1:0] hwErrEvent,
  output flagStrobes_t          strobes
);

  localparam int EN_MSB = ERR_EN_LSB + NUM_HW_ERR - 1;

  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] hwVec;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_decode
    assign setVec[i] = cmdValid & cmdWord[setBitOf(i)];
    assign clrVec[i] = cmdValid & cmdWord[clrBitOf(i)];
    if (i < NUM_HW_ERR) begin : g_hw
      // R6: event passes only with its control enable bit
      assign hwVec[i] = hwErrEvent[i] & ctrlWord[ERR_EN_LSB + i];
    end else begin : g_sw_only
      assign hwVec[i] = 1'b0;
    end
  end

  assign strobes = '{swSet: setVec, swClr: clrVec, hwSet: hwVec};

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{ctrlWord[CTRL_W-1:EN_MSB+1], ctrlWord[ERR_EN_LSB-1:0]};

endmodule

// File: rtl/sflag_datapath.sv
module sflag_datapath
  import sflag_pkg::*;
#(
  parameter int STAT_W     = 16,
  parameter int IEN_W      = 4,
  parameter int IRQ_EN_BIT = 2,
  parameter int BUSY_BIT   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strobes,
  input  logic              busyIn,
  input  logic [IEN_W-1:0]  intEnable,
  output logic [STAT_W-1:0] statusWord,
  output logic              errIrq
);

  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flagsNext;

  // Hardware set first, then a lone software set or clear; a conflicting pair holds
  always_comb begin
    for (int i = 0; i < NUM_FLAGS; i++) begin
      if (strobes.hwSet[i])
        flagsNext[i] = 1'b1;
      else if (strobes.swSet[i] != strobes.swClr[i])
        flagsNext[i] = strobes.swSet[i];
      else
        flagsNext[i] = flags[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_FLAGS; i++)
      statusWord[statBitOf(i)] = flags[i];
    statusWord[BUSY_BIT] = busyIn;
  end

  assign errIrq = (|flags[NUM_ERR-1:0]) & intEnable[IRQ_EN_BIT];

  logic unusedIenBits;
  assign unusedIenBits = ^{intEnable[IEN_W-1:IRQ_EN_BIT+1], intEnable[IRQ_EN_BIT-1:0]};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.swSet[i] && strobes.swClr[i] && !strobes.hwSet[i]) |=> $stable(flags[i]))
      else $error("conflicting set/clear changed flag %0d", i);
    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.hwSet[i] |=> flags[i])
      else $error("hardware set lost on flag %0d", i);
    // R3
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.swClr[i] && !strobes.swSet[i] && !strobes.hwSet[i]) |=> !flags[i])
      else $error("clear ignored on flag %0d", i);
  end

endmodule

// File: rtl/status_flag_bank.sv
module status_flag_bank
  import sflag_pkg::*;
#(
  parameter int CMD_W      = 16,
  parameter int CTRL_W     = 16,
  parameter int STAT_W     = 16,
  parameter int IEN_W      = 4,
  parameter int ERR_EN_LSB = 8,
  parameter int IRQ_EN_BIT = 2,
  parameter int BUSY_BIT   = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [CMD_W-1:0]      cmdWord,
  input  logic [CTRL_W-1:0]     ctrlWord,
  input  logic [NUM_HW_ERR-1:0] hwErrEvent,
  input  logic                  busyIn,
  input  logic [IEN_W-1:0]      intEnable,
  output logic [STAT_W-1:0]     statusWord,
  output logic                  errIrq
);

  flagStrobes_t strobes;

  sflag_ctrl #(
    .CMD_W(CMD_W), .CTRL_W(CTRL_W), .ERR_EN_LSB(ERR_EN_LSB)
  ) uCtrl (
    .cmdValid(cmdValid), .cmdWord(cmdWord), .ctrlWord(ctrlWord),
    .hwErrEvent(hwErrEvent), .strobes(strobes)
  );

  sflag_datapath #(
    .STAT_W(STAT_W), .IEN_W(IEN_W), .IRQ_EN_BIT(IRQ_EN_BIT), .BUSY_BIT(BUSY_BIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busyIn(busyIn),
    .intEnable(intEnable), .statusWord(statusWord), .errIrq(errIrq)
  );

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable[IRQ_EN_BIT] |-> !errIrq)
    else $error("error interrupt while masked");

  // R2
  en_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[statBitOf(IDX_RUN)]) |-> $past(cmdValid && cmdWord[setBitOf(IDX_RUN)]))
    else $error("enable flag rose without a set write");

endmodule

// File: tb/sim_status_flag_bank.sv
`timescale 1ns/1ps
module sim_status_flag_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [15:0] ctrlWord = '0;
  logic [4:0]  hwErrEvent = '0;
  logic        busyIn = 1'b0;
  logic [3:0]  intEnable = '0;
  logic [15:0] statusWord;
  logic        errIrq;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // Specification tables (R2, R3, R8): index 0 txovf,1 rxovf,2 abort,3 txunf,4 rxunf,5 mode err,6 master,7 enable
  int setPos [8] = '{12, 13, 14, 15, 5, 7, 3, 1};
  int clrPos [8] = '{8, 9, 10, 11, 4, 6, 2, 0};
  int statPos[8] = '{8, 9, 10, 11, 12, 7, 1, 0};
  logic [7:0] expFlags = '0;

  always #2 clk = ~clk;

  status_flag_bank u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .ctrlWord(ctrlWord), .hwErrEvent(hwErrEvent), .busyIn(busyIn),
    .intEnable(intEnable), .statusWord(statusWord), .errIrq(errIrq)
  );

  function automatic logic [15:0] expStatus();
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 8; i++) s[statPos[i]] = expFlags[i];
    s[13] = busyIn;
    return s;
  endfunction

  task automatic checkOut(input string req);
    logic [15:0] es;
    logic ei;
    es = expStatus();
    ei = (|expFlags[5:0]) & intEnable[2];
    totalCnt++;
    if (statusWord !== es || errIrq !== ei) begin
      failCnt++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               req, statusWord, errIrq, es, ei);
    end
  endtask

  // Called just after a falling edge; model the next flag state, pass one rising edge, check
  task automatic step(input logic v, input logic [15:0] w, input logic [15:0] c,
                      input logic [4:0] e, input string req);
    cmdValid = v; cmdWord = w; ctrlWord = c; hwErrEvent = e;
    for (int i = 0; i < 8; i++) begin
      logic s, k, h;
      s = v && w[setPos[i]];
      k = v && w[clrPos[i]];
      h = (i < 5) && e[i] && c[8+i];
      if (h) expFlags[i] = 1'b1;
      else if (s && !k) expFlags[i] = 1'b1;
      else if (k && !s) expFlags[i] = 1'b0;
    end
    @(negedge clk);
    cmdValid = 1'b0; cmdWord = '0; hwErrEvent = '0;
    #0.5;
    checkOut(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++; totalCnt++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    intEnable = 4'b0100;
    repeat (3) @(negedge clk);
    #0.5;
    checkOut("R1");            // reset state while reset held
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1");

    // R2 R3 R4: every flag, every set/clear pair, both start values
    for (int f = 0; f < 8; f++) begin
      for (int init = 0; init < 2; init++) begin
        for (int combo = 0; combo < 4; combo++) begin
          logic [15:0] w;
          string tag;
          w = '0;
          w[init ? setPos[f] : clrPos[f]] = 1'b1;
          step(1'b1, w, 16'h0000, 5'h0, init ? "R2" : "R3");
          w = '0;
          if (combo[0]) w[setPos[f]] = 1'b1;
          if (combo[1]) w[clrPos[f]] = 1'b1;
          tag = (combo == 3) ? "R4" : (combo == 2) ? "R3" : "R2";
          step(1'b1, w, 16'h0000, 5'h0, tag);
        end
      end
    end

    // R8: all flags set, every mapped bit visible
    step(1'b1, 16'hF0AA, 16'h0000, 5'h0, "R8");

    // R5: unqualified words change nothing
    step(1'b0, 16'h0F55, 16'h0000, 5'h0, "R5");
    step(1'b1, 16'h0F55, 16'h0000, 5'h0, "R3");
    step(1'b0, 16'hF0AA, 16'h0000, 5'h0, "R5");

    // R9: bulk error clear keeps enable and master select
    step(1'b1, 16'hF0AA, 16'h0000, 5'h0, "R2");
    step(1'b1, 16'h0F50, 16'h0000, 5'h0, "R9");

    // R6 R7: each hardware source against its own and a foreign enable, with and without a clear
    for (int e = 0; e < 5; e++) begin
      for (int en = 0; en < 3; en++) begin
        for (int clr = 0; clr < 2; clr++) begin
          logic [15:0] c;
          logic [15:0] w;
          step(1'b1, 16'h0F50, 16'h0000, 5'h0, "R9");
          c = '0;
          if (en == 1) c[8+e] = 1'b1;
          if (en == 2) c = 16'h1F00 & ~(16'h0100 << e);
          w = '0;
          if (clr) w[clrPos[e]] = 1'b1;
          step(clr[0], w, c, 5'h1 << e, (en == 1 && clr) ? "R7" : "R6");
        end
      end
    end

    // R10: every interrupt-enable value against no error and each single error flag
    for (int ien = 0; ien < 16; ien++) begin
      for (int f = -1; f < 6; f++) begin
        logic [15:0] w;
        intEnable = ien[3:0];
        step(1'b1, 16'h0F50, 16'h0000, 5'h0, "R10");
        w = '0;
        if (f >= 0) w[setPos[f]] = 1'b1;
        step(1'b1, w, 16'h0000, 5'h0, "R10");
      end
    end

    // R11: busy bit follows input within the cycle
    busyIn = 1'b1; #0.5; checkOut("R11");
    @(negedge clk); busyIn = 1'b0; #0.5; checkOut("R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule